// File: doc/BRIEF.md
# Access Protection Group Checker

This block decides whether one translated memory access may proceed. The matched translation entry supplies a protection group number. That number picks one 2-bit field out of a software-loaded protection register that holds one field per group. A global mode input sets how the chosen field is read.

- **Segment-key mode:** the field holds a supervisor key and a user key. The key that matches the current privilege level then changes how the page's own protection bits are applied. In this mode software is expected to load the group number with the top four bits of the effective page number.
- **Domain mode:** the field is an override. It can keep the page's protection, forbid all access, or grant all access.

The permit verdict is combinational from the current inputs and the stored register. A fault pulse follows one cycle after any checked access that is denied. The register is loaded whole through a write port. A load lands on the next clock edge, so a check made in the same cycle still sees the old contents.

Top module: `prot_group_checker`

## Requirements
- R1: The group number N selects register bits [2N+1:2N] as the active field, for every N from 0 to 15.
- R2: In segment-key mode (modeDomain=0), field bit 1 is the supervisor key and field bit 0 is the user key. The key used is the one for the current level (isUser=1 selects bit 0).
- R3: In segment-key mode, a selected key of 1 with page bits 2'b00 denies reads, writes and fetches.
- R4: In segment-key mode, a selected key of 1 with page bits 2'b01 denies writes and permits reads and fetches.
- R5: When the page bits apply directly, page bits 2'b11 deny writes and permit reads and fetches, and all other page bits permit every access. The page bits apply directly in segment-key mode with a key of 0, in segment-key mode with a key of 1 and page bits 2'b1x, and in domain mode with field 2'b01.
- R6: In domain mode (modeDomain=1), field 2'b00 and field 2'b10 deny every access, whatever the page bits.
- R7: In domain mode, field 2'b11 permits every access, including a write to a page with bits 2'b11.
- R8: In domain mode, field 2'b01 applies the page bits as in R5.
- R9: A register load (cfgWrEn=1) takes effect at the next rising clock edge. A check in the load cycle uses the previous contents.
- R10: fault is high for exactly the one cycle after a cycle with chkValid=1 and permit=0, and is low otherwise.
- R11: Reset (rstN=0) clears the register to all zeros and drives fault low.
- R12: Access type encoding: 2'b00 read, 2'b01 write, 2'b10 fetch, 2'b11 treated as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load the protection register |
| cfgWrData | input | 32 | New protection register contents, field N at bits [2N+1:2N] |
| modeDomain | input | 1 | 0 = segment-key mode, 1 = domain mode |
| chkValid | input | 1 | An access is being checked this cycle |
| groupId | input | 4 | Protection group number from the matched entry |
| pageProt | input | 2 | Page protection bits of the matched entry |
| isUser | input | 1 | 1 = user level, 0 = supervisor level |
| accType | input | 2 | Access type (R12) |
| permit | output | 1 | Combinational access verdict |
| fault | output | 1 | Registered denial pulse (R10) |

## Verification
The bench builds the block with its default parameters: 16 groups of 2-bit fields, which gives a 32-bit register and a 4-bit group number. With these defaults, random register loads and random group numbers reach every field position, and both modes meet every key and override value against every page-bit and access-type pair. Directed steps cover the reset contents, the boundary groups 0 and 15, and a load landing in the same cycle as a check on the field it changes.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_t;

  // page protection codes with special meaning
  localparam logic [1:0] PP_LOCKED  = 2'b00;
  localparam logic [1:0] PP_NOWRKEY = 2'b01;
  localparam logic [1:0] PP_RDONLY  = 2'b11;

  // domain override codes
  localparam logic [1:0] DOM_PAGE = 2'b01;
  localparam logic [1:0] DOM_FREE = 2'b11;

  typedef struct packed {
    logic loadReg;
    logic checkEn;
  } ctrl_strobe_t;

endpackage

// File: rtl/prot_dp.sv
module prot_dp
  import prot_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int FIELD_W    = 2,
  localparam int REG_W     = NUM_GROUPS * FIELD_W,
  localparam int GROUP_W   = $clog2(NUM_GROUPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [REG_W-1:0]   wrData,
  input  logic               modeDomain,
  input  logic [GROUP_W-1:0] groupId,
  input  logic [1:0]         pageProt,
  input  logic               isUser,
  input  logic [1:0]         accType,
  output logic               permit,
  output logic               denyHit
);

  logic [REG_W-1:0]   protReg;
  logic [FIELD_W-1:0] fieldArr [NUM_GROUPS];
  logic [FIELD_W-1:0] field;
  logic               isWrite;
  logic               pageOnly;
  logic               keyBit;
  logic               segPermit;
  logic               domPermit;

  always_ff @(posedge clk) begin
    if (!rstN)                protReg <= '0;
    else if (strobes.loadReg) protReg <= wrData;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gField
    assign fieldArr[g] = protReg[g*FIELD_W +: FIELD_W];
  end

  assign field   = fieldArr[groupId];
  assign isWrite = (acc_t'(accType) == ACC_WRITE);

  // page bits applied with no key and no override
  assign pageOnly = (pageProt == PP_RDONLY) ? !isWrite : 1'b1;

  assign keyBit = isUser ? field[0] : field[1];

  always_comb begin
    segPermit = pageOnly;
    if (keyBit) begin
      if (pageProt == PP_LOCKED)       segPermit = 1'b0;
      else if (pageProt == PP_NOWRKEY) segPermit = !isWrite;
    end
  end

  always_comb begin
    case (field)
      DOM_FREE: domPermit = 1'b1;
      DOM_PAGE: domPermit = pageOnly;
      default:  domPermit = 1'b0;
    endcase
  end

  assign permit  = modeDomain ? domPermit : segPermit;
  assign denyHit = strobes.checkEn & ~permit;

endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         chkValid,
  input  logic         denyHit,
  output ctrl_strobe_t strobes,
  output logic         fault
);

  assign strobes.loadReg = cfgWrEn;
  assign strobes.checkEn = chkValid;

  always_ff @(posedge clk) begin
    if (!rstN) fault <= 1'b0;
    else       fault <= denyHit;
  end

endmodule

// File: rtl/prot_group_checker.sv
module prot_group_checker
  import prot_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int FIELD_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWrEn,
  input  logic [NUM_GROUPS*FIELD_W-1:0]   cfgWrData,
  input  logic                            modeDomain,
  input  logic                            chkValid,
  input  logic [$clog2(NUM_GROUPS)-1:0]   groupId,
  input  logic [1:0]                      pageProt,
  input  logic                            isUser,
  input  logic [1:0]                      accType,
  output logic                            permit,
  output logic                            fault
);

  ctrl_strobe_t strobes;
  logic         denyHit;

  prot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .chkValid (chkValid),
    .denyHit  (denyHit),
    .strobes  (strobes),
    .fault    (fault)
  );

  prot_dp #(
    .NUM_GROUPS (NUM_GROUPS),
    .FIELD_W    (FIELD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (cfgWrData),
    .modeDomain (modeDomain),
    .groupId    (groupId),
    .pageProt   (pageProt),
    .isUser     (isUser),
    .accType    (accType),
    .permit     (permit),
    .denyHit    (denyHit)
  );

endmodule

// File: rtl/prot_group_checker_chk.sv
module prot_group_checker_chk #(
  parameter int NUM_GROUPS = 16,
  parameter int FIELD_W    = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgWrEn,
  input logic [NUM_GROUPS*FIELD_W-1:0] cfgWrData,
  input logic                          modeDomain,
  input logic                          chkValid,
  input logic [$clog2(NUM_GROUPS)-1:0] groupId,
  input logic [1:0]                    pageProt,
  input logic                          isUser,
  input logic [1:0]                    accType,
  input logic                          permit,
  input logic                          fault
);

  // shadow copy rebuilt from the load port only
  logic [NUM_GROUPS*FIELD_W-1:0] shadow;
  logic [1:0]                    selField;
  logic                          isWr;

  always_ff @(posedge clk) begin
    if (!rstN)        shadow <= '0;
    else if (cfgWrEn) shadow <= cfgWrData;
  end

  assign selField = shadow[groupId*FIELD_W +: 2];
  assign isWr     = (accType == 2'b01);

  AST_FAULT_AFTER_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !permit) |=> fault) else $error("fault missing");            // R10

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $past(chkValid && !permit)) else $error("spurious fault");      // R10

  AST_DOMAIN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (modeDomain && !selField[0]) |-> !permit) else $error("locked permit");   // R6

  AST_DOMAIN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (modeDomain && selField == 2'b11) |-> permit) else $error("free deny");   // R7

  AST_RDONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && pageProt == 2'b11 && !(modeDomain && selField == 2'b11)) |-> !permit)
    else $error("readonly write");                                             // R5

  AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!modeDomain && pageProt == 2'b00 && (isUser ? selField[0] : selField[1])) |-> !permit)
    else $error("key lock");                                                   // R3

endmodule

bind prot_group_checker prot_group_checker_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .FIELD_W    (FIELD_W)
) u_chk (.*);

// File: tb/sim_prot_group_checker.sv
`timescale 1ns/1ps
module sim_prot_group_checker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        modeDomain = 1'b0;
  logic        chkValid = 1'b0;
  logic [3:0]  groupId = '0;
  logic [1:0]  pageProt = '0;
  logic        isUser = 1'b0;
  logic [1:0]  accType = '0;
  logic        permit;
  logic        fault;

  int          errs = 0;
  int          checks = 0;
  logic [31:0] mReg = '0;
  logic        expFault = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  prot_group_checker u0 (.*);

  function automatic logic refPermit(logic [31:0] r, logic dom, logic [3:0] g,
                                     logic [1:0] pp, logic usr, logic [1:0] acc);
    logic [1:0] f = r[g*2 +: 2];
    logic wr = (acc == 2'b01);
    logic direct = (pp == 2'b11) ? !wr : 1'b1;
    logic k = usr ? f[0] : f[1];
    if (dom) begin
      if (f == 2'b11) return 1'b1;
      if (f == 2'b01) return direct;
      return 1'b0;
    end
    if (k && pp == 2'b00) return 1'b0;
    if (k && pp == 2'b01) return !wr;
    return direct;
  endfunction

  function automatic string reqOf(logic [31:0] r, logic dom, logic [3:0] g,
                                  logic [1:0] pp, logic usr);
    logic [1:0] f = r[g*2 +: 2];
    logic k = usr ? f[0] : f[1];
    if (dom) begin
      if (f == 2'b11) return "R7";
      if (f == 2'b01) return "R8";
      return "R6";
    end
    if (k && pp == 2'b00) return "R3";
    if (k && pp == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one access: drive after negedge, check permit, then edge, then fault
  task automatic access(logic wr, logic [31:0] wd, logic dom, logic v,
                        logic [3:0] g, logic [1:0] pp, logic usr, logic [1:0] acc,
                        string tag);
    logic ep;
    cfgWrEn = wr; cfgWrData = wd; modeDomain = dom; chkValid = v;
    groupId = g; pageProt = pp; isUser = usr; accType = acc;
    #1;
    ep = refPermit(mReg, dom, g, pp, usr, acc);
    check({tag, " R1 R2 R12 permit"}, permit, ep);
    expFault = v & ~ep;
    @(posedge clk);
    if (wr) mReg = wd;
    @(negedge clk);
    check("R10 fault", fault, expFault);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R11 fault in reset", fault, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 fault after reset", fault, 1'b0);
    // cleared register: domain mode group 15 denies, segment mode permits
    access(0, '0, 1, 1, 4'd15, 2'b10, 0, 2'b00, "R11");
    access(0, '0, 0, 1, 4'd0, 2'b00, 1, 2'b01, "R11");
    // boundary groups: only group 15 free, only group 0 free
    access(1, 32'hC000_0000, 1, 0, 4'd0, 2'b11, 0, 2'b01, "R1");
    access(0, '0, 1, 1, 4'd15, 2'b11, 0, 2'b01, "R1");
    access(0, '0, 1, 1, 4'd14, 2'b10, 0, 2'b00, "R1");
    // R9: load in same cycle as check on the changed field uses old contents
    access(1, 32'h0000_0003, 1, 1, 4'd15, 2'b11, 0, 2'b01, "R9");
    check("R9 register value after load", refPermit(mReg, 1, 4'd15, 2'b11, 0, 2'b01), 1'b0);
    access(0, '0, 1, 1, 4'd15, 2'b11, 0, 2'b01, "R9");
    access(0, '0, 1, 1, 4'd0, 2'b11, 0, 2'b01, "R9");
    // R2: key selection by level on group 5 (supervisor key 1, user key 0)
    access(1, 32'h0000_0800, 0, 0, 4'd0, 2'b00, 0, 2'b00, "R2");
    access(0, '0, 0, 1, 4'd5, 2'b00, 0, 2'b00, "R2");
    access(0, '0, 0, 1, 4'd5, 2'b00, 1, 2'b00, "R2");
    access(0, '0, 0, 1, 4'd5, 2'b01, 0, 2'b10, "R4");
    access(0, '0, 0, 1, 4'd5, 2'b01, 0, 2'b01, "R4");
    access(0, '0, 0, 1, 4'd5, 2'b11, 0, 2'b11, "R12");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic wr = ($urandom_range(0, 5) == 0);
      logic [31:0] wd = $urandom;
      logic dom = $urandom_range(0, 1);
      logic v = ($urandom_range(0, 3) != 0);
      logic [3:0] g = 4'($urandom_range(0, 15));
      logic [1:0] pp = 2'($urandom_range(0, 3));
      logic usr = $urandom_range(0, 1);
      logic [1:0] acc = 2'($urandom_range(0, 3));
      access(wr, wd, dom, v, g, pp, usr, acc, reqOf(mReg, dom, g, pp, usr));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule